// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block frames each serial word with active-low chip-select lines for a serial master. It takes queued words through a valid/ready handshake and finds the target for each one. In fixed mode the target comes from a static select field. In variable mode it comes from a select field that travels with each word. It then drives four select lines and starts an external shift engine with a one-cycle pulse, and it waits for that engine's done pulse. The shift engine itself sits outside this block.

Each target maps to one of four timing sets. A set gives the lead time from select to first clock, the hold time after each word, and the half SCK period used when the lead time is zero. The lines can be driven in two ways. In direct mode, a priority decode asserts one line. In encoded mode, the select value goes onto the lines unchanged so that an external decoder can expand it to sixteen targets. Two words in a row for the same target keep the select asserted. A change of target, or the end of the queue, raises all lines for a guard interval before any line falls again. At the end of every word the line pattern is captured and reported.

Top module: `spi_cs_seq`

## Requirements
- R1: In direct mode (dec_mode=0) the lines take the lowest-numbered zero bit of the 4-bit target: xxx0 gives 1110, xx01 gives 1101, x011 gives 1011, 0111 gives 0111. A target of 1111 leaves all lines at 1.
- R2: In encoded mode (dec_mode=1) the 4-bit target is driven onto cs_n as it is.
- R3: The timing set is picked as follows. In direct mode it is the index of the lowest zero bit of the target, and a target of 1111 uses set 3. In encoded mode it is target bits [3:2]. Set n occupies bits [8n+7:8n] of each per-set config bus.
- R4: With var_sel=0 the target is fix_sel and word_sel is ignored. With var_sel=1 the target is word_sel and fix_sel is ignored.
- R5: When the select comes up, exactly L cycles pass with the select active before shift_start. L is the set's lead value, or, if that value is 0, the set's half-period value with a minimum of 1.
- R6: After shift_done, exactly 32×T cycles pass before the next action, or 4 cycles when the set's hold value T is 0. A next word for the same line pattern is then started with the select held low throughout.
- R7: When the next target differs, or when no word is waiting, all lines go to 1 for exactly max(gap_cfg, 6) cycles before any line is asserted again.
- R8: cs_n is 1111 after reset and between select intervals. It moves away from an active pattern only by going to 1111.
- R9: In the cycle after shift_done, end_valid pulses and end_sel shows the cs_n pattern of that word.
- R10: Unless both enable and master are 1, cs_oe_n is 1111, no word is accepted, and cs_n is 1111 from the next cycle on. When both are 1, cs_oe_n is 0000.
- R11: word_ready and shift_start are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all delays count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Sequencer enabled |
| master | input | 1 | Master role selected |
| var_sel | input | 1 | 1: target from each word; 0: target from fix_sel |
| dec_mode | input | 1 | 1: encoded select output; 0: direct priority decode |
| fix_sel | input | NCS | Target used in fixed mode |
| gap_cfg | input | DW | Deselect-to-reselect guard, floor 6 |
| lead_cfg | input | NCS*DW | Per-set select-to-start delay |
| tail_cfg | input | NCS*DW | Per-set hold after word, ×32 |
| half_cfg | input | NCS*DW | Per-set half SCK period, used when lead is 0 |
| word_valid | input | 1 | A word is waiting |
| word_sel | input | NCS | Target carried by the waiting word |
| word_ready | output | 1 | Waiting word accepted this cycle |
| shift_start | output | 1 | Start pulse to the shift engine |
| shift_set | output | $clog2(NCS) | Timing set of the current target |
| shift_done | input | 1 | Shift engine finished the word |
| cs_n | output | NCS | Active-low select lines |
| cs_oe_n | output | NCS | Active-low output enables for the select lines |
| end_sel | output | NCS | Select pattern captured at end of word |
| end_valid | output | 1 | end_sel updated |

## Verification
An accept in cycle t brings the select up in cycle t+1. The bench samples on falling edges, so it counts the active-select cycles before shift_start and compares the count with L. Hold and guard intervals are measured in the same way. The bench counts the cycles from the bench-driven done pulse to the next start, and the run of all-ones cycles between two select patterns. The captured pattern is checked one falling edge after done, when end_valid is due. The idle state is checked only after a margin longer than the largest hold-plus-guard interval in use.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_FIRE,
        S_SHIFT,
        S_TAIL,
        S_GAP
    } seq_state_e;

    localparam int unsigned GAP_FLOOR  = 6;
    localparam int unsigned TAIL_ZERO  = 4;
    localparam int unsigned TAIL_SCALE = 32;

    // Cycles between select assertion and shift start.
    function automatic int unsigned lead_len(int unsigned lead, int unsigned half);
        if (lead != 0) return lead;
        return (half == 0) ? 1 : half;
    endfunction

    // Cycles held after a word completes.
    function automatic int unsigned tail_len(int unsigned tail);
        return (tail == 0) ? TAIL_ZERO : tail * TAIL_SCALE;
    endfunction

    // Cycles with all lines released before a new select.
    function automatic int unsigned gap_len(int unsigned gap);
        return (gap <= GAP_FLOOR) ? GAP_FLOOR : gap;
    endfunction

endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NCS = 4
) (
    input  logic                    enc,
    input  logic [NCS-1:0]          sel,
    output logic [NCS-1:0]          lines,
    output logic [$clog2(NCS)-1:0]  set
);
    localparam int SW = $clog2(NCS);

    always_comb begin
        logic found;
        found = 1'b0;
        lines = '1;
        set   = SW'(NCS - 1);
        if (enc) begin
            lines = sel;
            set   = sel[NCS-1 -: SW];
        end else begin
            for (int i = 0; i < NCS; i++) begin
                if (!found && !sel[i]) begin
                    lines[i] = 1'b0;
                    set      = SW'(i);
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_cs_delay.sv
module spi_cs_delay
    import spi_cs_pkg::*;
#(
    parameter int NCS = 4,
    parameter int DW  = 8,
    parameter int CW  = DW + 6
) (
    input  logic [NCS*DW-1:0]       lead_cfg,
    input  logic [NCS*DW-1:0]       tail_cfg,
    input  logic [NCS*DW-1:0]       half_cfg,
    input  logic [DW-1:0]           gap_cfg,
    input  logic [$clog2(NCS)-1:0]  set,
    output logic [CW-1:0]           lead_cyc,
    output logic [CW-1:0]           tail_cyc,
    output logic [CW-1:0]           gap_cyc
);
    logic [DW-1:0] lead_f, tail_f, half_f;

    assign lead_f   = lead_cfg[set*DW +: DW];
    assign tail_f   = tail_cfg[set*DW +: DW];
    assign half_f   = half_cfg[set*DW +: DW];
    assign lead_cyc = CW'(lead_len(32'(lead_f), 32'(half_f)));
    assign tail_cyc = CW'(tail_len(32'(tail_f)));
    assign gap_cyc  = CW'(gap_len(32'(gap_cfg)));
endmodule

// File: rtl/spi_cs_timer.sv
module spi_cs_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= len - CW'(1);
        else if (cnt != '0) cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int NCS = 4,
    parameter int DW  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    master,
    input  logic                    var_sel,
    input  logic                    dec_mode,
    input  logic [NCS-1:0]          fix_sel,
    input  logic [DW-1:0]           gap_cfg,
    input  logic [NCS*DW-1:0]       lead_cfg,
    input  logic [NCS*DW-1:0]       tail_cfg,
    input  logic [NCS*DW-1:0]       half_cfg,
    input  logic                    word_valid,
    input  logic [NCS-1:0]          word_sel,
    output logic                    word_ready,
    output logic                    shift_start,
    output logic [$clog2(NCS)-1:0]  shift_set,
    input  logic                    shift_done,
    output logic [NCS-1:0]          cs_n,
    output logic [NCS-1:0]          cs_oe_n,
    output logic [NCS-1:0]          end_sel,
    output logic                    end_valid
);
    localparam int SW = $clog2(NCS);
    localparam int CW = DW + 6;

    seq_state_e     state;
    logic [NCS-1:0] tgt, in_sel, dec_in, pick_lines, cs_q;
    logic [SW-1:0]  pick_set;
    logic           pend, active, accept, same, tmr_zero, tmr_load;
    logic [CW-1:0]  lead_cyc, tail_cyc, gap_cyc, tmr_len;

    assign active = enable & master;
    assign in_sel = var_sel ? word_sel : fix_sel;
    assign accept = active & word_valid &
                    ((state == S_IDLE) | ((state == S_TAIL) & tmr_zero));
    assign dec_in = accept ? in_sel : tgt;

    spi_cs_decode #(.NCS(NCS)) u_dec (
        .enc   (dec_mode),
        .sel   (dec_in),
        .lines (pick_lines),
        .set   (pick_set)
    );

    spi_cs_delay #(.NCS(NCS), .DW(DW), .CW(CW)) u_dly (
        .lead_cfg (lead_cfg),
        .tail_cfg (tail_cfg),
        .half_cfg (half_cfg),
        .gap_cfg  (gap_cfg),
        .set      (pick_set),
        .lead_cyc (lead_cyc),
        .tail_cyc (tail_cyc),
        .gap_cyc  (gap_cyc)
    );

    assign same = accept & (pick_lines == cs_q);

    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = lead_cyc;
        unique case (state)
            S_IDLE:  tmr_load = accept;
            S_GAP:   tmr_load = tmr_zero & pend;
            S_SHIFT: begin tmr_load = shift_done; tmr_len = tail_cyc; end
            S_TAIL:  begin tmr_load = tmr_zero & ~same; tmr_len = gap_cyc; end
            default: tmr_load = 1'b0;
        endcase
        if (!active) tmr_load = 1'b0;
    end

    spi_cs_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state     <= S_IDLE;
            tgt       <= '1;
            pend      <= 1'b0;
            cs_q      <= '1;
            end_sel   <= '0;
            end_valid <= 1'b0;
        end else begin
            end_valid <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    tgt   <= in_sel;
                    cs_q  <= pick_lines;
                    state <= S_LEAD;
                end
                S_LEAD:  if (tmr_zero) state <= S_FIRE;
                S_FIRE:  state <= S_SHIFT;
                S_SHIFT: if (shift_done) begin
                    end_sel   <= cs_q;
                    end_valid <= 1'b1;
                    state     <= S_TAIL;
                end
                S_TAIL: if (tmr_zero) begin
                    if (same) begin
                        state <= S_FIRE;
                    end else begin
                        cs_q  <= '1;
                        pend  <= accept;
                        state <= S_GAP;
                        if (accept) tgt <= in_sel;
                    end
                end
                S_GAP: if (tmr_zero) begin
                    pend <= 1'b0;
                    if (pend) begin
                        cs_q  <= pick_lines;
                        state <= S_LEAD;
                    end else begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign word_ready  = accept;
    assign shift_start = (state == S_FIRE);
    assign shift_set   = pick_set;
    assign cs_n        = cs_q;
    assign cs_oe_n     = active ? '0 : '1;
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           enable,
    input logic           word_ready,
    input logic           shift_start,
    input logic [NCS-1:0] cs_n,
    input logic [NCS-1:0] end_sel,
    input logic           end_valid
);
    p_start_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        shift_start |=> !shift_start);

    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        word_ready |=> !word_ready);

    p_cs_held_at_start_r6: assert property (@(posedge clk) disable iff (rst)
        shift_start |-> $stable(cs_n));

    p_cs_via_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(cs_n) != '1) && (cs_n != $past(cs_n))) |-> (cs_n == '1));

    p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cs_n == '1));

    p_end_capture_r9: assert property (@(posedge clk) disable iff (rst)
        end_valid |-> (end_sel == $past(cs_n)));
endmodule

bind spi_cs_seq spi_cs_seq_chk #(.NCS(NCS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .word_ready  (word_ready),
    .shift_start (shift_start),
    .cs_n        (cs_n),
    .end_sel     (end_sel),
    .end_valid   (end_valid)
);

// File: tb/sim_spi_cs_seq.sv
module sim_spi_cs_seq;
    localparam int CLK_NS = 10;
    localparam int NCS = 4;
    localparam int DW  = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic enable = 1'b0, master = 1'b1, var_sel = 1'b0, dec_mode = 1'b0;
    logic [NCS-1:0] fix_sel = '1, word_sel = '1;
    logic [DW-1:0] gap_cfg = '0;
    logic [NCS*DW-1:0] lead_cfg, tail_cfg, half_cfg;
    logic word_valid = 1'b0, word_ready, shift_start, shift_done, end_valid;
    logic [1:0] shift_set;
    logic [NCS-1:0] cs_n, cs_oe_n, end_sel;

    int lead_v[4] = '{3, 5, 7, 9};
    int tail_v[4] = '{1, 0, 0, 0};
    int half_v[4] = '{2, 2, 6, 2};
    int tests = 0, fails = 0, cyc = 0;

    always #(CLK_NS/2) clk = ~clk;

    spi_cs_seq #(.NCS(NCS), .DW(DW)) u0 (.*);

    // Shift engine model: done pulse a few cycles after each start.
    int sh_cnt = 0;
    always_ff @(posedge clk) begin
        shift_done <= 1'b0;
        if (shift_start) sh_cnt <= 5;
        else if (sh_cnt > 0) begin
            sh_cnt <= sh_cnt - 1;
            if (sh_cnt == 1) shift_done <= 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int i = 0; i < 4; i++) begin
            lead_cfg[i*DW +: DW] = DW'(lead_v[i]);
            tail_cfg[i*DW +: DW] = DW'(tail_v[i]);
            half_cfg[i*DW +: DW] = DW'(half_v[i]);
        end
    endtask

    function automatic int exp_set(input logic [3:0] s, input bit enc);
        if (enc) return int'(s[3:2]);
        for (int i = 0; i < 4; i++) if (!s[i]) return i;
        return 3;
    endfunction

    function automatic logic [3:0] exp_lines(input logic [3:0] s, input bit enc);
        int k;
        if (enc) return s;
        k = exp_set(s, 1'b0);
        if (s == 4'hF) return 4'hF;
        return ~(4'b0001 << k);
    endfunction

    function automatic int exp_lead(input int k);
        if (lead_v[k] != 0) return lead_v[k];
        return (half_v[k] == 0) ? 1 : half_v[k];
    endfunction

    // Present a word and return at the falling edge of the first select cycle.
    task automatic launch(input logic [3:0] s, input bit drop);
        if (var_sel) begin word_sel = s; fix_sel = ~s; end
        else begin fix_sel = s; word_sel = ~s; end
        word_valid = 1'b1;
        #1;
        while (!word_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        if (drop) word_valid = 1'b0;
    endtask

    task automatic one_word(input logic [3:0] s, input string req);
        int n;
        logic [3:0] el;
        el = exp_lines(s, dec_mode);
        launch(s, 1'b1);
        n = 0;
        while (!shift_start) begin n++; @(negedge clk); end
        chk(cs_n == el, {req, " lines"}, cs_n, el);
        chk(n == exp_lead(exp_set(s, dec_mode)), {req, " R3 R5 lead"}, n,
            exp_lead(exp_set(s, dec_mode)));
        @(negedge clk);
        chk(!shift_start, "R11 start pulse", shift_start, 0);
        while (!shift_done) @(negedge clk);
        @(negedge clk);
        chk(end_valid && end_sel == el, "R9 end capture", end_sel, el);
        repeat (80) @(negedge clk);
        chk(cs_n == 4'hF, "R8 idle lines", cs_n, 15);
    endtask

    initial begin
        int n, hit;
        apply_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 4'hF && !word_ready && !shift_start && !end_valid,
            "R8 reset state", cs_n, 15);
        chk(cs_oe_n == 4'hF, "R10 oe off at reset", cs_oe_n, 15);

        // R10: disabled, then slave role: nothing accepted.
        for (int m = 0; m < 2; m++) begin
            enable = (m == 1); master = (m == 0);
            word_valid = 1'b1; fix_sel = 4'b1110;
            hit = 0;
            repeat (20) begin @(negedge clk); if (word_ready || cs_n != 4'hF) hit++; end
            chk(hit == 0, "R10 inactive ignores words", hit, 0);
            chk(cs_oe_n == 4'hF, "R10 oe off inactive", cs_oe_n, 15);
        end
        word_valid = 1'b0; enable = 1'b1; master = 1'b1;
        @(negedge clk);
        chk(cs_oe_n == 4'h0, "R10 oe on active", cs_oe_n, 0);

        // R1 R4: direct decode, fixed target, full sweep.
        var_sel = 1'b0; dec_mode = 1'b0;
        for (int s = 0; s < 16; s++) one_word(4'(s), "R1 R4 direct fixed");

        // R2 R4: encoded decode, per-word target, full sweep.
        var_sel = 1'b1; dec_mode = 1'b1;
        for (int s = 0; s < 16; s++) one_word(4'(s), "R2 R4 encoded variable");

        // R5: zero lead uses half period.
        var_sel = 1'b0; dec_mode = 1'b0;
        lead_v[2] = 0; apply_cfg();
        one_word(4'b1011, "R5 zero lead");
        half_v[2] = 0; apply_cfg();
        one_word(4'b0011, "R5 zero lead floor");

        // R6: same target back to back, hold x32 and zero-hold.
        var_sel = 1'b1;
        for (int k = 0; k < 2; k++) begin
            logic [3:0] s;
            s = (k == 0) ? 4'b1110 : 4'b1101;
            launch(s, 1'b0);
            while (!shift_done) @(negedge clk);
            @(negedge clk);
            n = 0; hit = 0;
            while (!shift_start) begin
                n++;
                if (cs_n != exp_lines(s, 1'b0)) hit++;
                @(negedge clk);
            end
            word_valid = 1'b0;
            chk(n == ((tail_v[k] == 0) ? 4 : 32 * tail_v[k]), "R6 hold length",
                n, (tail_v[k] == 0) ? 4 : 32 * tail_v[k]);
            chk(hit == 0, "R6 select held", hit, 0);
            repeat (80) @(negedge clk);
        end

        // R7: target change gap with floor.
        for (int g = 0; g < 3; g++) begin
            int gv, ge;
            gv = (g == 0) ? 3 : (g == 1) ? 6 : 10;
            ge = (gv <= 6) ? 6 : gv;
            gap_cfg = DW'(gv);
            launch(4'b1101, 1'b0);
            word_sel = 4'b0111;
            while (!shift_done) @(negedge clk);
            while (cs_n != 4'hF) @(negedge clk);
            n = 0;
            while (cs_n == 4'hF) begin n++; @(negedge clk); end
            word_valid = 1'b0;
            chk(n == ge, "R7 guard length", n, ge);
            chk(cs_n == 4'b0111, "R7 new select", cs_n, 7);
            repeat (100) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule